// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time and date in BCD: seconds, minutes, hours, date, month, two-digit year and day of week. It takes a clock enable at 32.768 kHz and divides it down so the time moves forward once per second. The counting handles the length of each month and leap years. The hour can be read and written in 24-hour form or in 12-hour form with an AM/PM flag. A bench or a fast test mode can drive a bypass enable that moves time forward one second per pulse, without using the divider.

A bus front end sets and reads the fields through a simple register port. A write port (enable, address, byte) takes one byte in any cycle. There is no back-pressure and no ready signal. The read data is combinational from the read address. The block also drives a one-cycle pulse each time the time moves forward, for use by other logic. After reset the counter stays frozen until a time byte has been written.

Register addresses: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week; address 7 is unused.

Top module: `cal_time_keeper`

## Requirements
- R1: After reset, all registers read 00 except date and month, which read 01. The day of week reads 0 and `sec_tick` is low.
- R2: Time does not advance after reset until a byte is written to one of addresses 0 to 6. A write to address 7 does not start the clock and has no effect; address 7 always reads 00.
- R3: The clock advances once every PRESCALE_DIV cycles in which `ref_en` is high. Each `fast_tick` pulse also advances the clock by one second.
- R4: A write to a time address clears the divider. The next advance comes after exactly PRESCALE_DIV further `ref_en` cycles.
- R5: Seconds and minutes count in BCD from 00 to 59. On wrapping to 00, each carries one into the next field.
- R6: In 24-hour mode (`hr12_mode`=0), the hour byte is BCD 00 to 23. A step from 23:59:59 gives 00:00:00 and advances the date.
- R7: In 12-hour mode (`hr12_mode`=1), the hour byte has bit 5 as the PM flag and bits 4:0 as BCD 01 to 12. Hour 12 AM means midnight. A step from 11:59:59 gives 12:00:00 and toggles PM.
- R8: Months 04, 06, 09 and 11 roll to date 01 after date 30. Months 01, 03, 05, 07, 08, 10 and 12 roll after date 31.
- R9: February rolls after date 29 when the year is divisible by 4 (year 00 included). In other years it rolls after date 28.
- R10: After 31 December, the date becomes 01 January and the year increments in BCD. Year 99 wraps to 00.
- R11: The day of week counts 0 to 6 and wraps to 0. It advances whenever the date advances.
- R12: `sec_tick` is high for one cycle, in the first cycle in which the advanced time is readable.
- R13: If a time write and an advance fall in the same cycle, the written value is kept and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | 32.768 kHz clock enable |
| fast_tick | input | 1 | Divider bypass: advance one second |
| hr12_mode | input | 1 | 1 = 12-hour AM/PM format, 0 = 24-hour format |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write byte |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read byte (combinational) |
| sec_tick | output | 1 | One-cycle pulse per advance |

## Verification
The bench targets these cases. It checks that the counter stays frozen both before the first write and after a write to the unused address; a design that started on any write would count too early. It drives the counter across month ends for 30-day months, 31-day months and February in leap and non-leap years, including year 00, and across the year wrap; a wrong month-length table would skip a date or invent one. It checks the 12-hour noon and midnight changes, and hour conversion in both directions, where a wrong conversion would show 00 instead of 12 or leave PM unchanged. It also times the divider to the exact cycle after a write and checks a write that collides with an advance; a design that did not clear the divider would tick early, and one that let the advance win would return the written value plus one.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_DATE = 3'd3,
    F_MONTH = 3'd4, F_YEAR = 3'd5, F_DOW = 3'd6, F_NONE = 3'd7
  } field_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return {3'b0, v[7:4]} * 7'd10 + {3'b0, v[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] b);
    logic [6:0] t, o;
    t = b / 7'd10;
    o = b % 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] month, input logic [7:0] year);
    logic [6:0] yb;
    yb = bcd2bin(year);
    case (month)
      8'h02: last_day = (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default: last_day = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_prescale.sv
module cal_prescale #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic clr,
  output logic wrap
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign wrap = ref_en && (cnt_q == LAST) && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (ref_en) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/cal_tod.sv
module cal_tod
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr_en,
  input  field_e     wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_carry
);
  logic sec_top, min_top, hour_top;
  assign sec_top   = (sec_q == 8'h59);
  assign min_top   = (min_q == 8'h59);
  assign hour_top  = (hour_q == 8'h23);
  assign day_carry = adv && sec_top && min_top && hour_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        F_SEC:  sec_q  <= wr_data & 8'h7F;
        F_MIN:  min_q  <= wr_data & 8'h7F;
        F_HOUR: hour_q <= wr_data & 8'h3F;
        default: ;
      endcase
    end else if (adv) begin
      sec_q <= sec_top ? 8'h00 : bcd_inc(sec_q);
      if (sec_top) begin
        min_q <= min_top ? 8'h00 : bcd_inc(min_q);
        if (min_top) hour_q <= hour_top ? 8'h00 : bcd_inc(hour_q);
      end
    end
  end

  p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && sec_q == 8'h59) |=> (sec_q == 8'h00));
  p_hour_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h23) |=> (hour_q == 8'h00));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)));
endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_adv,
  input  logic       wr_en,
  input  field_e     wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q,
  output logic [7:0] dow_q
);
  logic [7:0] last;
  assign last = last_day(month_q, year_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
      dow_q   <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        F_DATE:  date_q  <= wr_data & 8'h3F;
        F_MONTH: month_q <= wr_data & 8'h1F;
        F_YEAR:  year_q  <= wr_data;
        F_DOW:   dow_q   <= wr_data & 8'h07;
        default: ;
      endcase
    end else if (day_adv) begin
      dow_q <= (dow_q >= 8'h06) ? 8'h00 : dow_q + 8'h01;
      if (date_q >= last) begin
        date_q <= 8'h01;
        if (month_q >= 8'h12) begin
          month_q <= 8'h01;
          year_q  <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        end else begin
          month_q <= bcd_inc(month_q);
        end
      end else begin
        date_q <= bcd_inc(date_q);
      end
    end
  end

  p_dow_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !wr_en && dow_q == 8'h06) |=> (dow_q == 8'h00));
  p_year_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !wr_en && month_q == 8'h12 && date_q == 8'h31) |=> (month_q == 8'h01 && date_q == 8'h01 && year_q != $past(year_q)));
  p_leap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !wr_en && month_q == 8'h02 && date_q == 8'h28 && year_q == 8'h24) |=> (date_q == 8'h29));
endmodule

// File: rtl/cal_time_keeper.sv
module cal_time_keeper
  import cal_pkg::*;
#(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       fast_tick,
  input  logic       hr12_mode,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sec_tick
);
  field_e     wr_sel, rd_sel;
  logic       time_wr, run_q, pre_wrap, adv, day_carry, tick_q;
  logic [7:0] core_wdata, hour_w, hour_r;
  logic [7:0] sec_q, min_q, hour_q, date_q, month_q, year_q, dow_q;
  logic [6:0] hb_w, h24_w, hb_r, h12_r;

  assign wr_sel  = field_e'(wr_addr);
  assign rd_sel  = field_e'(rd_addr);
  assign time_wr = wr_en && (wr_sel != F_NONE);
  assign adv     = run_q && !time_wr && (pre_wrap || fast_tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (time_wr) run_q <= 1'b1;
      tick_q <= adv;
    end
  end
  assign sec_tick = tick_q;

  // hour conversion on the write side
  always_comb begin
    hb_w  = bcd2bin({3'b0, wr_data[4:0]});
    h24_w = ((hb_w == 7'd12) ? 7'd0 : hb_w) + (wr_data[5] ? 7'd12 : 7'd0);
    hour_w = hr12_mode ? bin2bcd(h24_w) : (wr_data & 8'h3F);
    core_wdata = (wr_sel == F_HOUR) ? hour_w : wr_data;
  end

  cal_prescale #(.DIV(PRESCALE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .clr(time_wr), .wrap(pre_wrap)
  );

  cal_tod u_tod (
    .clk(clk), .rst_n(rst_n), .adv(adv), .wr_en(time_wr), .wr_sel(wr_sel),
    .wr_data(core_wdata), .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
    .day_carry(day_carry)
  );

  cal_date u_date (
    .clk(clk), .rst_n(rst_n), .day_adv(day_carry), .wr_en(time_wr), .wr_sel(wr_sel),
    .wr_data(core_wdata), .date_q(date_q), .month_q(month_q), .year_q(year_q),
    .dow_q(dow_q)
  );

  // hour conversion on the read side
  always_comb begin
    logic [7:0] h12_bcd;
    hb_r    = bcd2bin(hour_q);
    h12_r   = hb_r % 7'd12;
    if (h12_r == 7'd0) h12_r = 7'd12;
    h12_bcd = bin2bcd(h12_r);
    hour_r  = hr12_mode ? {2'b00, (hb_r >= 7'd12), h12_bcd[4:0]} : hour_q;
  end

  always_comb begin
    case (rd_sel)
      F_SEC:   rd_data = sec_q;
      F_MIN:   rd_data = min_q;
      F_HOUR:  rd_data = hour_r;
      F_DATE:  rd_data = date_q;
      F_MONTH: rd_data = month_q;
      F_YEAR:  rd_data = year_q;
      F_DOW:   rd_data = dow_q;
      default: rd_data = 8'h00;
    endcase
  end

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !sec_tick);
  p_write_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> !sec_tick);
  p_tick_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !time_wr && fast_tick) |=> sec_tick);
endmodule

// File: tb/cal_time_keeper_tb_top.sv
module cal_time_keeper_tb_top;
  localparam int DIV = 32768;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0, fast_tick = 1'b0, hr12_mode = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0, rd_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sec_tick;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  cal_time_keeper #(.PRESCALE_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .fast_tick(fast_tick),
    .hr12_mode(hr12_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    fast_tick = 1'b1;
    @(negedge clk);
    fast_tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
    wr(3'd5, yr); wr(3'd4, mo); wr(3'd3, dt); wr(3'd6, dw);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
  endtask

  task automatic t_reset();
    check("R1 tick low", {7'b0, sec_tick}, 8'h00);
    chk_reg("R1 sec", 3'd0, 8'h00);
    chk_reg("R1 hour", 3'd2, 8'h00);
    chk_reg("R1 date", 3'd3, 8'h01);
    chk_reg("R1 month", 3'd4, 8'h01);
    chk_reg("R1 year", 3'd5, 8'h00);
    chk_reg("R1 dow", 3'd6, 8'h00);
  endtask

  task automatic t_frozen();
    tick();
    chk_reg("R2 frozen sec", 3'd0, 8'h00);
    wr(3'd7, 8'h55);
    tick();
    chk_reg("R2 addr7 no start", 3'd0, 8'h00);
    chk_reg("R2 addr7 reads 0", 3'd7, 8'h00);
  endtask

  task automatic t_seconds();
    wr(3'd0, 8'h58);
    tick();
    chk_reg("R3 fast tick sec", 3'd0, 8'h59);
    check("R12 tick high", {7'b0, sec_tick}, 8'h01);
    @(negedge clk);
    check("R12 tick one cycle", {7'b0, sec_tick}, 8'h00);
    tick();
    chk_reg("R5 sec wrap", 3'd0, 8'h00);
    chk_reg("R5 min carry", 3'd1, 8'h01);
  endtask

  task automatic t_day24();
    hr12_mode = 1'b0;
    set_all(8'h21, 8'h03, 8'h15, 8'h06, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R6 hour wrap", 3'd2, 8'h00);
    chk_reg("R6 min wrap", 3'd1, 8'h00);
    chk_reg("R6 date step", 3'd3, 8'h16);
    chk_reg("R11 dow wrap", 3'd6, 8'h00);
    tick();
    chk_reg("R6 no extra day", 3'd3, 8'h16);
  endtask

  task automatic t_months();
    set_all(8'h21, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R8 april date", 3'd3, 8'h01);
    chk_reg("R8 april month", 3'd4, 8'h05);
    chk_reg("R11 dow step", 3'd6, 8'h03);
    set_all(8'h21, 8'h01, 8'h30, 8'h00, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R8 jan 31 exists", 3'd3, 8'h31);
    set_all(8'h21, 8'h11, 8'h30, 8'h00, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R8 nov month", 3'd4, 8'h12);
  endtask

  task automatic t_feb();
    set_all(8'h24, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R9 leap 29", 3'd3, 8'h29);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tick();
    chk_reg("R9 leap roll month", 3'd4, 8'h03);
    set_all(8'h23, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R9 common roll date", 3'd3, 8'h01);
    chk_reg("R9 common roll month", 3'd4, 8'h03);
    set_all(8'h00, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R9 year00 leap", 3'd3, 8'h29);
  endtask

  task automatic t_year();
    set_all(8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R10 year wrap", 3'd5, 8'h00);
    chk_reg("R10 month jan", 3'd4, 8'h01);
    chk_reg("R10 date 1", 3'd3, 8'h01);
    set_all(8'h19, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R10 bcd year", 3'd5, 8'h20);
  endtask

  task automatic t_12h();
    hr12_mode = 1'b1;
    set_all(8'h21, 8'h05, 8'h10, 8'h01, 8'h11, 8'h59, 8'h59);
    tick();
    chk_reg("R7 noon", 3'd2, 8'h32);
    wr(3'd2, 8'h31); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tick();
    chk_reg("R7 midnight", 3'd2, 8'h12);
    chk_reg("R7 midnight date", 3'd3, 8'h11);
    wr(3'd2, 8'h12);
    hr12_mode = 1'b0;
    chk_reg("R7 12AM as 24h", 3'd2, 8'h00);
    hr12_mode = 1'b1;
    wr(3'd2, 8'h21);
    hr12_mode = 1'b0;
    chk_reg("R7 1PM as 24h", 3'd2, 8'h13);
  endtask

  task automatic t_collide();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30; fast_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; fast_tick = 1'b0;
    chk_reg("R13 write kept", 3'd0, 8'h30);
    check("R13 no tick", {7'b0, sec_tick}, 8'h00);
  endtask

  task automatic t_divider();
    @(negedge clk);
    ref_en = 1'b1;
    repeat (1000) @(negedge clk);
    wr(3'd0, 8'h10);
    repeat (DIV - 1) @(negedge clk);
    chk_reg("R4 not yet", 3'd0, 8'h10);
    @(negedge clk);
    chk_reg("R3 divided advance", 3'd0, 8'h11);
    check("R12 tick on divide", {7'b0, sec_tick}, 8'h01);
    ref_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frozen();
    t_seconds();
    t_day24();
    t_months();
    t_feb();
    t_year();
    t_12h();
    t_collide();
    t_divider();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule